// File: doc/BRIEF.md
# Power-on strap sampler for dual-role clock pins

This block manages two pads that serve as configuration inputs while power comes up and as clock outputs afterwards. Once the digital supply-good indication rises, both pad drivers stay in high impedance for a fixed number of reference-clock cycles. During that time an external pull resistor sets each pad's level. When the window ends, the block stores each pad's level, marks the stored values valid, and on the next cycle turns the pad drivers on.

Pad 0 is the output-rate select strap. After capture it drives the reference clock. Pad 1 is the high frequency-select strap. After capture it drives either the 24 MHz or the 48 MHz clock, as chosen by the stored level of pad 0. The stored values feed selects elsewhere in the chip. Only a loss of supply clears them. If supply-good falls at any point, the block returns to the high-impedance sampling state, and the whole window starts again when supply-good rises.

Top module: `strap_sampler`

## Requirements
- R1: On every clock edge where supply_good_i is low, the block clears strap_valid_o, pad_oe_o and strap_o to all zeros, and pad_out_o reads zero.
- R2: pad_oe_o stays 0 for as long as strap_valid_o is 0. Neither pad is driven while sampling.
- R3: strap_valid_o rises on the WINDOW_CYCLES-th consecutive rising edge at which supply_good_i is high. It does not rise on any earlier edge.
- R4: At that edge, strap_o[i] takes the level of pad_in_i[i]. A low pad stores 0 and a high pad stores 1.
- R5: While supply_good_i stays high, strap_o does not change after capture, whatever pad_in_i does.
- R6: pad_oe_o becomes 2'b11 on the edge after strap_valid_o rises, and stays there while supply_good_i is high.
- R7: While driving, pad_out_o[0] follows ref_clk_i. pad_out_o[1] follows clk24_i when strap_o[0] is 1 and follows clk48_i when it is 0.
- R8: sel_24m_o equals strap_o[0], where 1 means 24 MHz. fs1_o equals strap_o[1], which is bit 1 of the pin frequency code.
- R9: If supply_good_i falls during the window, the count restarts from zero. The next capture needs a full WINDOW_CYCLES edges after supply_good_i rises again.
- R10: If supply_good_i falls after capture, the drivers go back to high impedance. When supply returns, the pads' new levels are sampled.
- R11: pad_out_o[i] is 0 whenever pad_oe_o[i] is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock that times the window |
| supply_good_i | input | 1 | High while the supply is above its valid threshold; low acts as power loss |
| pad_in_i | input | 2 | Level seen on each pad (strap level while undriven) |
| ref_clk_i | input | 1 | Reference-rate clock driven onto pad 0 |
| clk24_i | input | 1 | 24 MHz clock candidate for pad 1 |
| clk48_i | input | 1 | 48 MHz clock candidate for pad 1 |
| pad_out_o | output | 2 | Value driven on each pad |
| pad_oe_o | output | 2 | Driver enable per pad; 0 means high impedance |
| strap_o | output | 2 | Captured strap levels |
| strap_valid_o | output | 1 | Captured levels are meaningful |
| sel_24m_o | output | 1 | 1 selects 24 MHz, 0 selects 48 MHz on pad 1 |
| fs1_o | output | 1 | Frequency-select bit 1 taken from pad 1 |

## Verification
The bench counts edges from the rise of supply-good and checks the capture edge exactly. A timer that is off by one would raise valid a cycle early or late, or would sample the pad on the wrong edge. It drops supply partway through a window to show that the count restarts; a timer that resumes counting would capture too soon. After capture it toggles the pads to catch a latch that keeps following the pad, and it checks that drivers stay off until one cycle after valid. Across random strap pairs it checks the 24/48 choice on pad 1, which shows up a swapped select polarity or swapped pad roles.

// File: rtl/strap_pkg.sv
package strap_pkg;

    localparam int STRAP_PINS = 2;
    localparam int PIN_RATE   = 0;   // strap: 1 -> 24 MHz, 0 -> 48 MHz
    localparam int PIN_FSEL   = 1;   // strap: frequency-select bit 1

    typedef enum logic [1:0] {
        ST_SAMPLE = 2'd0,
        ST_LATCH  = 2'd1,
        ST_RUN    = 2'd2
    } seq_state_e;

    typedef struct packed {
        logic capture;   // load latches on this edge
        logic valid;     // latches hold captured levels
        logic drive;     // pad drivers enabled
    } seq_ctl_t;

    function automatic logic pick_fast_clk(input logic sel24, input logic c24, input logic c48);
        return sel24 ? c24 : c48;
    endfunction

endpackage

// File: rtl/strap_window_timer.sv
module strap_window_timer
    import strap_pkg::*;
#(
    parameter int WINDOW_CYCLES = 28636
) (
    input  logic     clk_i,
    input  logic     supply_good_i,
    output seq_ctl_t ctl_o
);
    localparam int          CW   = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(WINDOW_CYCLES - 1);

    seq_state_e    state_q;
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (!supply_good_i) begin
            state_q <= ST_SAMPLE;
            cnt_q   <= '0;
        end else begin
            case (state_q)
                ST_SAMPLE: begin
                    if (cnt_q == LAST) state_q <= ST_LATCH;
                    else               cnt_q   <= cnt_q + 1'b1;
                end
                ST_LATCH: state_q <= ST_RUN;
                default:  state_q <= ST_RUN;
            endcase
        end
    end

    always_comb begin
        ctl_o.capture = supply_good_i && (state_q == ST_SAMPLE) && (cnt_q == LAST);
        ctl_o.valid   = (state_q != ST_SAMPLE);
        ctl_o.drive   = (state_q == ST_RUN);
    end

endmodule

// File: rtl/strap_capture_bank.sv
module strap_capture_bank
    import strap_pkg::*;
#(
    parameter int PINS = STRAP_PINS
) (
    input  logic            clk_i,
    input  logic            supply_good_i,
    input  logic            capture_i,
    input  logic [PINS-1:0] pad_in_i,
    output logic [PINS-1:0] strap_o
);
    for (genvar i = 0; i < PINS; i++) begin : g_latch
        logic bit_q;
        always_ff @(posedge clk_i) begin
            if (!supply_good_i)  bit_q <= 1'b0;
            else if (capture_i)  bit_q <= pad_in_i[i];
        end
        assign strap_o[i] = bit_q;
    end

endmodule

// File: rtl/strap_pad_mux.sv
module strap_pad_mux
    import strap_pkg::*;
(
    input  logic                  drive_i,
    input  logic [STRAP_PINS-1:0] strap_i,
    input  logic                  ref_clk_i,
    input  logic                  clk24_i,
    input  logic                  clk48_i,
    output logic [STRAP_PINS-1:0] pad_out_o,
    output logic [STRAP_PINS-1:0] pad_oe_o
);
    logic [STRAP_PINS-1:0] src;

    always_comb begin
        src           = '0;
        src[PIN_RATE] = ref_clk_i;
        src[PIN_FSEL] = pick_fast_clk(strap_i[PIN_RATE], clk24_i, clk48_i);
        pad_oe_o      = {STRAP_PINS{drive_i}};
        pad_out_o     = src & pad_oe_o;
    end

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
    import strap_pkg::*;
#(
    parameter int WINDOW_CYCLES = 28636
) (
    input  logic       clk_i,
    input  logic       supply_good_i,
    input  logic [1:0] pad_in_i,
    input  logic       ref_clk_i,
    input  logic       clk24_i,
    input  logic       clk48_i,
    output logic [1:0] pad_out_o,
    output logic [1:0] pad_oe_o,
    output logic [1:0] strap_o,
    output logic       strap_valid_o,
    output logic       sel_24m_o,
    output logic       fs1_o
);
    seq_ctl_t ctl;

    strap_window_timer #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_timer (
        .clk_i        (clk_i),
        .supply_good_i(supply_good_i),
        .ctl_o        (ctl)
    );

    strap_capture_bank #(.PINS(STRAP_PINS)) u_bank (
        .clk_i        (clk_i),
        .supply_good_i(supply_good_i),
        .capture_i    (ctl.capture),
        .pad_in_i     (pad_in_i),
        .strap_o      (strap_o)
    );

    strap_pad_mux u_mux (
        .drive_i  (ctl.drive),
        .strap_i  (strap_o),
        .ref_clk_i(ref_clk_i),
        .clk24_i  (clk24_i),
        .clk48_i  (clk48_i),
        .pad_out_o(pad_out_o),
        .pad_oe_o (pad_oe_o)
    );

    assign strap_valid_o = ctl.valid;
    assign sel_24m_o     = strap_o[PIN_RATE];
    assign fs1_o         = strap_o[PIN_FSEL];

endmodule

// File: rtl/strap_sampler_chk.sv
module strap_sampler_chk #(
    parameter int WINDOW_CYCLES = 28636
) (
    input logic       clk_i,
    input logic       supply_good_i,
    input logic [1:0] pad_out_o,
    input logic [1:0] pad_oe_o,
    input logic [1:0] strap_o,
    input logic       strap_valid_o
);
    localparam int CW = $clog2(WINDOW_CYCLES + 2);

    logic [CW-1:0] up_cnt;
    always_ff @(posedge clk_i) begin
        if (!supply_good_i)      up_cnt <= '0;
        else if (!strap_valid_o) up_cnt <= up_cnt + 1'b1;
    end

    // R2
    a_r2_no_drive_early: assert property (@(posedge clk_i) disable iff (!supply_good_i)
        !strap_valid_o |-> (pad_oe_o == 2'b00));

    // R3
    a_r3_window_length: assert property (@(posedge clk_i) disable iff (!supply_good_i)
        $rose(strap_valid_o) |-> (up_cnt == CW'(WINDOW_CYCLES)));

    // R5
    a_r5_strap_hold: assert property (@(posedge clk_i) disable iff (!supply_good_i)
        (strap_valid_o && $past(strap_valid_o)) |-> $stable(strap_o));

    // R6
    a_r6_enable_follows: assert property (@(posedge clk_i) disable iff (!supply_good_i)
        $rose(strap_valid_o) |=> (pad_oe_o == 2'b11));

    // R11
    a_r11_quiet_when_off: assert property (@(posedge clk_i) disable iff (!supply_good_i)
        (pad_out_o & ~pad_oe_o) == 2'b00);

endmodule

bind strap_sampler strap_sampler_chk #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_chk (
    .clk_i        (clk_i),
    .supply_good_i(supply_good_i),
    .pad_out_o    (pad_out_o),
    .pad_oe_o     (pad_oe_o),
    .strap_o      (strap_o),
    .strap_valid_o(strap_valid_o)
);

// File: tb/strap_sampler_test.sv
module strap_sampler_test;
    localparam int WIN = 16;

    logic       clk = 1'b0;
    logic       supply = 1'b0;
    logic [1:0] pad_in = 2'b00;
    logic       ref_clk = 1'b0, c24 = 1'b0, c48 = 1'b0;
    logic [1:0] pad_out, pad_oe, strap;
    logic       valid, sel24, fs1;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #10 clk = ~clk;

    strap_sampler #(.WINDOW_CYCLES(WIN)) uut (
        .clk_i(clk), .supply_good_i(supply), .pad_in_i(pad_in),
        .ref_clk_i(ref_clk), .clk24_i(c24), .clk48_i(c48),
        .pad_out_o(pad_out), .pad_oe_o(pad_oe), .strap_o(strap),
        .strap_valid_o(valid), .sel_24m_o(sel24), .fs1_o(fs1)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic [1:0] exp_pads(input logic [1:0] s, input logic r,
                                            input logic a, input logic b);
        return {(s[0] ? a : b), r};
    endfunction

    task automatic tick();
        @(posedge clk); @(negedge clk);
    endtask

    // Raise supply with given straps and follow the window edge by edge.
    task automatic power_up(input logic [1:0] s);
        pad_in = s; ref_clk = 1'b1; c24 = 1'b1; c48 = 1'b1;
        supply = 1'b1;
        for (int k = 0; k <= WIN; k++) begin
            tick();
            if (k < WIN - 1) begin
                chk("R3 valid low in window", {7'b0, valid}, 8'h00);
                chk("R2 no drive in window", {6'b0, pad_oe}, 8'h00);
                chk("R11 pad quiet in window", {6'b0, pad_out}, 8'h00);
            end else if (k == WIN - 1) begin
                chk("R3 valid at capture edge", {7'b0, valid}, 8'h01);
                chk("R4 captured level", {6'b0, strap}, {6'b0, s});
                chk("R2 no drive at capture", {6'b0, pad_oe}, 8'h00);
            end else begin
                chk("R6 drive after valid", {6'b0, pad_oe}, 8'h03);
            end
        end
        chk("R8 select outputs", {6'b0, fs1, sel24}, {6'b0, s});
    endtask

    task automatic power_down();
        supply = 1'b0;
        tick();
        chk("R1 cleared on supply loss", {3'b0, valid, pad_oe, strap}, 8'h00);
        chk("R1 R10 pads undriven", {6'b0, pad_out}, 8'h00);
    endtask

    initial begin
        void'($urandom(32'd4711));
        tick(); tick();
        chk("R1 reset state", {3'b0, valid, pad_oe, strap}, 8'h00);

        // directed: each strap pair
        for (int s = 0; s < 4; s++) begin
            power_up(2'(s));
            for (int m = 0; m < 8; m++) begin
                {ref_clk, c24, c48} = 3'(m);
                #1;
                chk("R7 output mux", {6'b0, pad_out},
                    {6'b0, exp_pads(2'(s), ref_clk, c24, c48)});
            end
            power_down();
        end

        // R9: supply loss mid-window restarts the count
        pad_in = 2'b01; supply = 1'b1;
        repeat (WIN - 3) tick();
        chk("R9 not yet valid", {7'b0, valid}, 8'h00);
        supply = 1'b0; tick(); tick();
        power_up(2'b10);

        // R5: pads move after capture, straps hold
        for (int j = 0; j < 6; j++) begin
            pad_in = ~pad_in;
            tick();
            chk("R5 strap hold", {6'b0, strap}, 8'h02);
        end
        // R10: loss after capture then new levels sampled
        power_down();
        power_up(2'b01);
        power_down();

        // random
        for (int it = 0; it < 20; it++) begin
            logic [1:0] s;
            s = 2'($urandom_range(0, 3));
            power_up(s);
            for (int j = 0; j < 4; j++) begin
                {ref_clk, c24, c48} = 3'($urandom_range(0, 7));
                pad_in = 2'($urandom_range(0, 3));
                tick();
                chk("R7 random mux", {6'b0, pad_out},
                    {6'b0, exp_pads(s, ref_clk, c24, c48)});
                chk("R5 random hold", {6'b0, strap}, {6'b0, s});
            end
            power_down();
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            done = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule